// File: doc/BRIEF.md
# Partitioned Prefix SIMD Adder

A purely combinational 64-bit adder that a 2-bit mode input can split into independent lanes of 8, 16, 32 or 64 bits. Both operands pass through eight 8-bit slices. Each slice reduces its bits to one slice-level generate/propagate pair by running a small parallel-prefix scan. A second prefix scan joins these pairs across the eight slices. At each slice that opens a lane, the propagate link is cut and the shared carry-in is fed in at that point. One fixed network therefore serves every lane split, and no carry crosses from one lane into the next.

Each slice forms its own sum bits from its incoming carry and its internal prefix terms. The block reports one carry-out flag for each slice. A flag is meaningful only at the most significant slice of a lane and is held at zero elsewhere. The block is meant for datapaths that do packed arithmetic on bytes, half-words or words. It can also do one full-width add with the same hardware.

Top module: `pfx_simd_adder`

## Requirements
- R1: With mode 2'b11 the block forms one 64-bit lane: sum_o equals (a_i + b_i + cin_i) mod 2^64, and cout_o[7] is the carry out of bit 63.
- R2: With mode 2'b10 the block forms two 32-bit lanes (bits 31:0 and 63:32). Each lane's sum is its operand halves plus cin_i modulo 2^32, and the lane carries appear on cout_o[3] and cout_o[7].
- R3: With mode 2'b01 the block forms four 16-bit lanes. Each lane adds its own operand fields plus cin_i modulo 2^16, and the lane carries appear on cout_o[1], cout_o[3], cout_o[5] and cout_o[7].
- R4: With mode 2'b00 the block forms eight 8-bit lanes. Byte k of sum_o is byte k of a_i plus byte k of b_i plus cin_i modulo 256, and its carry appears on cout_o[k].
- R5: No carry crosses an active lane boundary. A lane whose operands sum to all ones plus carry-in 1 wraps to zero and leaves the next lane unchanged.
- R6: An entry of cout_o that is not at the top slice of a lane in the current mode reads zero.
- R7: The single cin_i is applied at the least significant bit of every lane, so with zero operands every lane sums to cin_i.
- R8: The slice-level generate and propagate of any 8-bit slice are never both one, and the cross-slice prefix never propagates past a lane's first slice.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | 64 | First operand |
| b_i | input | 64 | Second operand |
| mode_i | input | 2 | Lane split: 00 = 8x8, 01 = 4x16, 10 = 2x32, 11 = 1x64 |
| cin_i | input | 1 | Carry-in applied to every lane |
| sum_o | output | 64 | Lane-wise sums |
| cout_o | output | 8 | Carry-out per slice; valid only at lane tops, zero elsewhere |

## Verification
Immediate assertions run on every evaluation. They check that each slice's generate and propagate never both assert. They check that the cross-slice prefix stops at every lane start, and that the number of lane tops matches the selected mode. They also compare full-width and byte-wide results against direct arithmetic. The middle lane widths, the zeroing of carry flags at non-top slices and the wrap of all-ones lanes without leaking are shown only by the bench. Its scenarios compare every mode against a bit-serial, lane-by-lane reference model, using random, corner and carry-in operands.

// File: rtl/pfx_add_pkg.sv
`timescale 1ns/1ps
package pfx_add_pkg;
    localparam int unsigned SLICE_W  = 8;
    localparam int unsigned N_SLICE  = 8;
    localparam int unsigned DATA_W   = SLICE_W * N_SLICE;
    localparam int unsigned MODE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        SPLIT_8X8  = 2'b00,
        SPLIT_4X16 = 2'b01,
        SPLIT_2X32 = 2'b10,
        SPLIT_1X64 = 2'b11
    } split_e;
endpackage

// File: rtl/pfx_ks_scan.sv
`timescale 1ns/1ps
// Parallel-prefix (Kogge-Stone form) scan over generate/propagate pairs.
// Every node drives at most two successors, keeping fan-out bounded.
module pfx_ks_scan #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] g_i,
    input  logic [N-1:0] p_i,
    output logic [N-1:0] g_o,
    output logic [N-1:0] p_o
);
    localparam int unsigned LV = (N > 1) ? $clog2(N) : 1;

    logic [N-1:0] gs_d [0:LV];
    logic [N-1:0] ps_d [0:LV];

    always_comb begin
        gs_d[0] = g_i;
        ps_d[0] = p_i;
        for (int l = 0; l < LV; l++) begin
            for (int i = 0; i < N; i++) begin
                if (i >= (1 << l)) begin
                    gs_d[l+1][i] = gs_d[l][i] | (ps_d[l][i] & gs_d[l][i-(1<<l)]);
                    ps_d[l+1][i] = ps_d[l][i] & ps_d[l][i-(1<<l)];
                end else begin
                    gs_d[l+1][i] = gs_d[l][i];
                    ps_d[l+1][i] = ps_d[l][i];
                end
            end
        end
    end

    assign g_o = gs_d[LV];
    assign p_o = ps_d[LV];
endmodule

// File: rtl/pfx_slice.sv
`timescale 1ns/1ps
// One adder slice: bit generate/propagate, in-slice prefix, sum formation.
module pfx_slice #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         grp_g_o,
    output logic         grp_p_o
);
    logic [W-1:0] bit_g_d, bit_p_d;
    logic [W-1:0] pre_g_d, pre_p_d;
    logic [W-1:0] carry_d;

    assign bit_g_d = a_i & b_i;
    assign bit_p_d = a_i ^ b_i;

    pfx_ks_scan #(.N(W)) u_scan (
        .g_i (bit_g_d),
        .p_i (bit_p_d),
        .g_o (pre_g_d),
        .p_o (pre_p_d)
    );

    always_comb begin
        carry_d[0] = cin_i;
        for (int j = 1; j < W; j++) begin
            carry_d[j] = pre_g_d[j-1] | (pre_p_d[j-1] & cin_i);
        end
        sum_o = bit_p_d ^ carry_d;
    end

    assign grp_g_o = pre_g_d[W-1];
    assign grp_p_o = pre_p_d[W-1];

    // A slice cannot both create and pass a carry.
    always_comb begin
        p_gp_exclusive_r8: assert (!(grp_g_o && grp_p_o))
            else $error("slice generate and propagate both set");
    end
endmodule

// File: rtl/pfx_lane_decode.sv
`timescale 1ns/1ps
// Turns the mode into lane-start and lane-top masks over the slices.
module pfx_lane_decode
    import pfx_add_pkg::*;
#(
    parameter int unsigned N = N_SLICE
) (
    input  logic [MODE_W-1:0] mode_i,
    output logic [N-1:0]      start_o,
    output logic [N-1:0]      top_o
);
    int unsigned lane_mask_d;

    always_comb begin
        lane_mask_d = (32'd1 << mode_i) - 32'd1;
        for (int i = 0; i < N; i++) begin
            start_o[i] = ((i & lane_mask_d) == 0);
            top_o[i]   = (((i + 1) & lane_mask_d) == 0);
        end
    end

    always_comb begin
        p_top_count_r6: assert ($countones(top_o) == (N >> mode_i))
            else $error("lane top count does not match mode");
        p_base_start_r7: assert (start_o[0])
            else $error("lowest slice is not a lane start");
    end
endmodule

// File: rtl/pfx_carry_net.sv
`timescale 1ns/1ps
// Cross-slice carry combination. Lane starts have propagate cut and
// carry-in merged into their generate, so one prefix scan serves all splits.
module pfx_carry_net #(
    parameter int unsigned N = 8
) (
    input  logic [N-1:0] grp_g_i,
    input  logic [N-1:0] grp_p_i,
    input  logic [N-1:0] start_i,
    input  logic         cin_i,
    output logic [N-1:0] slice_cin_o,
    output logic [N-1:0] slice_cout_o
);
    logic [N-1:0] leaf_g_d, leaf_p_d;
    logic [N-1:0] scan_g_d, scan_p_d;

    assign leaf_g_d = grp_g_i | (start_i & grp_p_i & {N{cin_i}});
    assign leaf_p_d = grp_p_i & ~start_i;

    pfx_ks_scan #(.N(N)) u_scan (
        .g_i (leaf_g_d),
        .p_i (leaf_p_d),
        .g_o (scan_g_d),
        .p_o (scan_p_d)
    );

    always_comb begin
        slice_cin_o[0] = cin_i;
        for (int i = 1; i < N; i++) begin
            slice_cin_o[i] = start_i[i] ? cin_i : scan_g_d[i-1];
        end
        slice_cout_o = scan_g_d;
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            // The prefix must not reach across a lane start.
            p_no_prop_past_start_r8: assert (!(start_i[i] && scan_p_d[i]))
                else $error("prefix propagates across lane start %0d", i);
            // A lane-start slice that only propagates passes the carry-in.
            p_start_passes_cin_r5: assert (!(start_i[i] && grp_p_i[i] && !grp_g_i[i])
                                            || (slice_cout_o[i] == cin_i))
                else $error("lane start %0d did not pass carry-in", i);
        end
    end
endmodule

// File: rtl/pfx_simd_adder.sv
`timescale 1ns/1ps
module pfx_simd_adder
    import pfx_add_pkg::*;
(
    input  logic [DATA_W-1:0]  a_i,
    input  logic [DATA_W-1:0]  b_i,
    input  logic [MODE_W-1:0]  mode_i,
    input  logic               cin_i,
    output logic [DATA_W-1:0]  sum_o,
    output logic [N_SLICE-1:0] cout_o
);
    logic [N_SLICE-1:0] grp_g_d, grp_p_d;
    logic [N_SLICE-1:0] start_d, top_d;
    logic [N_SLICE-1:0] slice_cin_d, slice_cout_d;

    pfx_lane_decode #(.N(N_SLICE)) u_decode (
        .mode_i  (mode_i),
        .start_o (start_d),
        .top_o   (top_d)
    );

    for (genvar k = 0; k < N_SLICE; k++) begin : g_slice
        pfx_slice #(.W(SLICE_W)) u_slice (
            .a_i     (a_i[k*SLICE_W +: SLICE_W]),
            .b_i     (b_i[k*SLICE_W +: SLICE_W]),
            .cin_i   (slice_cin_d[k]),
            .sum_o   (sum_o[k*SLICE_W +: SLICE_W]),
            .grp_g_o (grp_g_d[k]),
            .grp_p_o (grp_p_d[k])
        );
    end

    pfx_carry_net #(.N(N_SLICE)) u_net (
        .grp_g_i      (grp_g_d),
        .grp_p_i      (grp_p_d),
        .start_i      (start_d),
        .cin_i        (cin_i),
        .slice_cin_o  (slice_cin_d),
        .slice_cout_o (slice_cout_d)
    );

    assign cout_o = slice_cout_d & top_d;

    always_comb begin
        if (mode_i == SPLIT_1X64) begin
            p_full_width_r1: assert ({cout_o[N_SLICE-1], sum_o} ==
                ({1'b0, a_i} + {1'b0, b_i} + {{DATA_W{1'b0}}, cin_i}))
                else $error("full-width sum mismatch");
        end
        if (mode_i == SPLIT_8X8) begin
            for (int k = 0; k < N_SLICE; k++) begin
                p_byte_lane_r4: assert ({cout_o[k], sum_o[k*SLICE_W +: SLICE_W]} ==
                    ({1'b0, a_i[k*SLICE_W +: SLICE_W]} + {1'b0, b_i[k*SLICE_W +: SLICE_W]}
                     + {{SLICE_W{1'b0}}, cin_i}))
                    else $error("byte lane %0d mismatch", k);
            end
        end
    end
endmodule

// File: tb/tb_pfx_simd_adder.sv
`timescale 1ns/1ps
module tb_pfx_simd_adder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] a, b;
    logic [1:0]  mode;
    logic        cin;
    logic [63:0] sum;
    logic [7:0]  cout;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [63:0] exp_sum;
        logic [7:0]  exp_cout;
        logic [7:0]  top_mask;
        string       tag;
    } item_t;

    item_t q [$];

    always #10 clk = ~clk;

    pfx_simd_adder dut (
        .a_i (a), .b_i (b), .mode_i (mode), .cin_i (cin),
        .sum_o (sum), .cout_o (cout)
    );

    function automatic string mode_tag(input logic [1:0] m);
        case (m)
            2'b11:   return "R1";
            2'b10:   return "R2";
            2'b01:   return "R3";
            default: return "R4";
        endcase
    endfunction

    // Bit-serial, lane-by-lane reference.
    function automatic item_t model(input logic [63:0] x, input logic [63:0] y,
                                    input logic [1:0] m, input logic ci, input string tg);
        item_t it;
        int lane_bits = 8 << m;
        logic c;
        it.exp_sum = '0;
        it.exp_cout = '0;
        it.top_mask = '0;
        for (int l = 0; l < 64 / lane_bits; l++) begin
            c = ci;
            for (int k = l * lane_bits; k < (l + 1) * lane_bits; k++) begin
                it.exp_sum[k] = x[k] ^ y[k] ^ c;
                c = (x[k] & y[k]) | (x[k] & c) | (y[k] & c);
            end
            it.exp_cout[((l + 1) * lane_bits) / 8 - 1] = c;
            it.top_mask[((l + 1) * lane_bits) / 8 - 1] = 1'b1;
        end
        it.tag = (tg == "") ? mode_tag(m) : tg;
        return it;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [63:0] x, input logic [63:0] y,
                         input logic [1:0] m, input logic ci, input string tg);
        @(posedge clk);
        #1;
        a = x; b = y; mode = m; cin = ci;
        q.push_back(model(x, y, m, ci, tg));
    endtask

    // Monitor: compares at the falling edge, away from input changes.
    initial begin
        item_t it;
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                it = q.pop_front();
                check(it.tag, sum, it.exp_sum);
                check(mode_tag(mode), {56'd0, cout & it.top_mask}, {56'd0, it.exp_cout});
                check("R6", {56'd0, cout & ~it.top_mask}, 64'd0);
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        a = '0; b = '0; mode = 2'b00; cin = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R4", sum, 64'd0);               // idle state, zero operands
        check("R6", {56'd0, cout}, 64'd0);
        rst_n = 1'b1;

        for (int m = 0; m < 4; m++) begin
            // R7: zero operands, carry-in 1 -> every lane reads 1
            drive(64'd0, 64'd0, 2'(m), 1'b1, "R7");
            // R5: all-ones lanes plus carry-in wrap to zero without leaking
            drive({64{1'b1}}, 64'd0, 2'(m), 1'b1, "R5");
            drive({64{1'b1}}, {64{1'b1}}, 2'(m), 1'b1, "");
            // R5: alternating lanes saturate; neighbours must stay untouched
            drive(64'h00FF_00FF_00FF_00FF, 64'h0000_0001_0000_0001, 2'(m), 1'b0, "R5");
            drive(64'h0000_FFFF_0000_FFFF, 64'h0000_0000_0000_0001, 2'(m), 1'b0, "R5");
            drive(64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0000, 2'(m), 1'b1, "R5");
            drive(64'h8080_8080_8080_8080, 64'h8080_8080_8080_8080, 2'(m), 1'b0, "");
        end
        for (int n = 0; n < 200; n++) begin
            drive({$urandom, $urandom}, {$urandom, $urandom}, 2'(n % 4), 1'($urandom), "");
        end
        while (q.size() > 0) @(posedge clk);
        @(posedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule